// File: doc/BRIEF.md
# Reset Generation Unit

This block produces a bank of individual reset outputs, each controlled by software through a small register bus. The bus has an address, a write enable, write data and a registered read-data return. There are two control words and two status words. Each reset line has one bit in one control word and the matching bit in one status word. Writing a 1 to a control bit fires that line.

Most lines are self-clearing. A write starts a pulse of fixed length, and the line drops by itself when the pulse ends. Two lines are level-held instead: they stay asserted until a write to their word carries 0 in their bit. Status bits read back inverted, so a 0 means the line is active. To keep the held lines asserted, software writes back the inverted status with the new request bits ORed in.

Line 0 is the whole-system reset. Firing it restarts every other line and returns the block to its power-on state.

Top module: `rstgen_unit`

## Requirements
- R1: After the synchronous reset `rst`, every output in `rst_out` is 0, both control words read 0 and both status words read all ones.
- R2: Control words sit at byte addresses 0x100 and 0x104, and status words at 0x150 and 0x154. The first word of each pair holds lines 0–31 and the second holds lines 32–63. Line n is bit n%32 of word n/32.
- R3: Read data is registered. `rd_data` shows the word addressed in the previous cycle, taken from the line states before that clock edge. A status bit is the inverse of its line: 0 while active, 1 while inactive.
- R4: Writing 1 to a self-clearing line raises its output at the write edge. The output stays high for exactly PULSE_CYCLES cycles (default 16) and then returns to 0 without further writes.
- R5: Writing 1 to a self-clearing line whose pulse is running restarts the pulse. This includes a write at the edge where the pulse would have ended. The output then stays high for PULSE_CYCLES cycles counted from the latest write.
- R6: Writing 0 to a self-clearing line while its pulse runs has no effect. The pulse ends at its original time.
- R7: Lines 12 and 56 are level-held. A write with 1 in their bit raises them, and they stay high for any length of time. Only a write to their own control word that carries 0 in their bit lowers them. A later write that carries 1 keeps them high.
- R8: Reads of any other address return 0. This covers unaligned addresses. Writes to the status words or to any other address change no line.
- R9: Writing 1 to bit 0 of the first control word starts a PULSE_CYCLES system-reset pulse on line 0. At that same edge, every other line goes inactive, including held lines and running pulses, even when the same write sets other bits. Writes are ignored until line 0 drops. Afterwards the block is in its power-on state.
- R10: A control bit reads 1 while its line is active and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Registered read data for the previous cycle's address |
| rst_out | output | 64 | Active-high reset lines, one per bit |

## Verification
Two functions can collide in a single clock edge.

The first collision is a restart and an expiry: a second write of 1 lands on the very edge where a running pulse would otherwise expire. The expected result is an unbroken high output for another full PULSE_CYCLES, with no one-cycle gap.

The second collision is the system reset and other requests in one write: the write that fires line 0 also carries 1s for a held line and a self-clearing line. The expected result is that only line 0 rises, and a write issued during the system pulse leaves every other line low.

Both cases are judged by sampling `rst_out` on each cycle boundary around the collision.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int unsigned LINES_PER_WORD = 32;
  localparam int unsigned WORD_STRIDE    = 4;
endpackage

// File: rtl/rstgen_regif.sv
module rstgen_regif
  import rstgen_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CTRL_BASE = 'h100,
  parameter int unsigned STAT_BASE = 'h150
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic                                wr_en,
  input  logic [NUM_WORDS*LINES_PER_WORD-1:0] line_state,
  output logic [NUM_WORDS-1:0]                wr_stb,
  output logic [LINES_PER_WORD-1:0]           rd_data
);
  logic [NUM_WORDS-1:0]      ctrl_hit;
  logic [NUM_WORDS-1:0]      stat_hit;
  logic [LINES_PER_WORD-1:0] rd_next;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_BASE + WORD_STRIDE * w);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_BASE + WORD_STRIDE * w);
    assign ctrl_hit[w] = (addr == CTRL_ADDR);
    assign stat_hit[w] = (addr == STAT_ADDR);
    assign wr_stb[w]   = wr_en && ctrl_hit[w];
  end

  always_comb begin
    rd_next = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (ctrl_hit[w]) rd_next = line_state[w*LINES_PER_WORD +: LINES_PER_WORD];
      if (stat_hit[w]) rd_next = ~line_state[w*LINES_PER_WORD +: LINES_PER_WORD];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R8: an address outside the map returns zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (ctrl_hit == '0 && stat_hit == '0) |=> rd_data == '0);
  // R2: at most one control word is addressed at a time
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb));
endmodule

// File: rtl/rstgen_line.sv
module rstgen_line #(
  parameter int unsigned PULSE_CYCLES = 16,
  parameter bit          HELD         = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic active
);
  logic active_q;
  assign active = active_q;

  if (HELD) begin : g_held
    always_ff @(posedge clk) begin
      if (rst || clr)  active_q <= 1'b0;
      else if (wr_stb) active_q <= wr_bit;
    end

    // R7: a held line stays up while its word is not written
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      (!wr_stb && !clr && active_q) |=> active_q);
    // R7: a write to its word sets the held level
    a_r7_follow: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && !clr) |=> (active_q == $past(wr_bit)));
  end else begin : g_pulse
    localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);
    logic [CW-1:0] left_q;
    logic [CW:0]   run_q;
    logic          start;
    assign start = wr_stb && wr_bit;

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        active_q <= 1'b0;
        left_q   <= '0;
      end else if (start) begin
        active_q <= 1'b1;
        left_q   <= CW'(PULSE_CYCLES - 1);
      end else if (left_q != '0) begin
        left_q   <= left_q - 1'b1;
      end else begin
        active_q <= 1'b0;
      end
    end

    // checker: cycles since the latest start
    always_ff @(posedge clk) begin
      if (rst || clr)    run_q <= '0;
      else if (start)    run_q <= (CW+1)'(1);
      else if (active_q) run_q <= run_q + 1'b1;
      else               run_q <= '0;
    end

    // R4: a start raises the line at the write edge
    a_r4_start: assert property (@(posedge clk) disable iff (rst)
      (start && !clr) |=> active_q);
    // R4: the line is never high longer than the pulse length
    a_r4_max_len: assert property (@(posedge clk) disable iff (rst)
      active_q |-> (run_q >= 1 && run_q <= (CW+1)'(PULSE_CYCLES)));
    // R6: a zero write does not cut a running pulse short
    a_r6_zero_ignored: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && !wr_bit && !clr && active_q && left_q != '0) |=> active_q);
  end

  // R9: a system clear drops the line at the next edge
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !active_q);
endmodule

// File: rtl/rstgen_unit.sv
module rstgen_unit
  import rstgen_pkg::*;
#(
  parameter int unsigned NUM_LINES    = 64,
  parameter int unsigned PULSE_CYCLES = 16,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned CTRL_BASE    = 'h100,
  parameter int unsigned STAT_BASE    = 'h150,
  parameter int unsigned HELD_LO      = 12,
  parameter int unsigned HELD_HI      = 56,
  parameter int unsigned SYS_LINE     = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr_en,
  input  logic [LINES_PER_WORD-1:0] bus_wr_data,
  output logic [LINES_PER_WORD-1:0] bus_rd_data,
  output logic [NUM_LINES-1:0]      rst_out
);
  localparam int unsigned NUM_WORDS = NUM_LINES / LINES_PER_WORD;
  localparam int unsigned SYS_WORD  = SYS_LINE / LINES_PER_WORD;
  localparam int unsigned SYS_BIT   = SYS_LINE % LINES_PER_WORD;

  logic [NUM_WORDS-1:0] wr_stb;
  logic [NUM_LINES-1:0] line_state;
  logic                 sys_active;
  logic                 sys_start;

  assign sys_active = line_state[SYS_LINE];
  assign sys_start  = wr_stb[SYS_WORD] && bus_wr_data[SYS_BIT] && !sys_active;
  assign rst_out    = line_state;

  rstgen_regif #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W),
    .CTRL_BASE (CTRL_BASE),
    .STAT_BASE (STAT_BASE)
  ) u_regif (
    .clk        (clk),
    .rst        (rst),
    .addr       (bus_addr),
    .wr_en      (bus_wr_en),
    .line_state (line_state),
    .wr_stb     (wr_stb),
    .rd_data    (bus_rd_data)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam bit IS_HELD = (n == HELD_LO) || (n == HELD_HI);
    localparam bit IS_SYS  = (n == SYS_LINE);
    logic line_clr;
    logic line_stb;
    if (IS_SYS) begin : g_sys
      assign line_clr = 1'b0;
      assign line_stb = wr_stb[n / LINES_PER_WORD] && !sys_active;
    end else begin : g_other
      assign line_clr = sys_active || sys_start;
      assign line_stb = wr_stb[n / LINES_PER_WORD];
    end
    rstgen_line #(
      .PULSE_CYCLES (PULSE_CYCLES),
      .HELD         (IS_HELD && !IS_SYS)
    ) u_line (
      .clk    (clk),
      .rst    (rst),
      .clr    (line_clr),
      .wr_stb (line_stb),
      .wr_bit (bus_wr_data[n % LINES_PER_WORD]),
      .active (line_state[n])
    );
  end

  // R9: while the system line is up no other line is up
  a_r9_sys_exclusive: assert property (@(posedge clk) disable iff (rst)
    rst_out[SYS_LINE] |-> $countones(rst_out) == 1);
  // R3: a status read returns the inverted first word of line states
  a_r3_status_read: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(bus_addr) == ADDR_W'(STAT_BASE)) |->
      bus_rd_data == ~$past(rst_out[LINES_PER_WORD-1:0]));
  // R10: a control read returns the first word of line states
  a_r10_ctrl_read: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(bus_addr) == ADDR_W'(CTRL_BASE)) |->
      bus_rd_data == $past(rst_out[LINES_PER_WORD-1:0]));
endmodule

// File: tb/tb_rstgen_unit.sv
`timescale 1ns/1ps
module tb_rstgen_unit;
  localparam int P = 16;
  localparam logic [11:0] CTRL0 = 12'h100, CTRL1 = 12'h104;
  localparam logic [11:0] STAT0 = 12'h150, STAT1 = 12'h154;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wr_data = '0;
  logic [31:0] bus_rd_data;
  logic [63:0] rst_out;
  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  rstgen_unit dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data), .rst_out(rst_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  // all tasks start and return just after a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wr_data = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rd_data;
  endtask

  task automatic t_por();
    logic [31:0] d;
    chk("R1 outputs after reset", rst_out, 64'h0);
    rd(CTRL0, d); chk("R1 ctrl0 reads 0", {32'h0, d}, 64'h0);
    rd(CTRL1, d); chk("R1 ctrl1 reads 0", {32'h0, d}, 64'h0);
    rd(STAT0, d); chk("R1 stat0 all ones", {32'h0, d}, 64'hFFFF_FFFF);
    rd(STAT1, d); chk("R1 stat1 all ones", {32'h0, d}, 64'hFFFF_FFFF);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(CTRL1, 32'h8);
    chk("R2 ctrl1 bit3 drives line 35", rst_out, 64'h1 << 35);
    rd(CTRL1, d); chk("R10 ctrl1 reads active line", {32'h0, d}, 64'h8);
    rd(STAT1, d); chk("R3 stat1 inverted", {32'h0, d}, {32'h0, ~32'h8});
    repeat (P) @(negedge clk);
    chk("R4 line 35 expired", rst_out, 64'h0);
  endtask

  task automatic t_pulse();
    logic ok = 1'b1;
    wr(CTRL0, 32'h20);
    chk("R4 line 5 rises at write", rst_out, 64'h20);
    for (int i = 1; i < P; i++) begin
      @(negedge clk);
      if (rst_out !== 64'h20) ok = 1'b0;
    end
    chk("R4 line 5 high for full pulse", {63'h0, ok}, 64'h1);
    @(negedge clk);
    chk("R4 line 5 low after pulse", rst_out, 64'h0);
  endtask

  task automatic t_restart();
    wr(CTRL1, 32'h100);                  // line 40
    repeat (P - 1) @(negedge clk);
    wr(CTRL1, 32'h100);                  // lands on the expiry edge
    chk("R5 restart at expiry keeps line up", rst_out, 64'h1 << 40);
    repeat (P - 1) @(negedge clk);
    chk("R5 still up at end of new pulse", rst_out, 64'h1 << 40);
    @(negedge clk);
    chk("R5 drops after restarted pulse", rst_out, 64'h0);
  endtask

  task automatic t_zero();
    wr(CTRL0, 32'h4);                    // line 2
    repeat (2) @(negedge clk);
    wr(CTRL0, 32'h0);
    chk("R6 zero write leaves pulse up", rst_out, 64'h4);
    repeat (P - 4) @(negedge clk);
    chk("R6 pulse reaches its original end", rst_out, 64'h4);
    @(negedge clk);
    chk("R6 pulse ends on time", rst_out, 64'h0);
  endtask

  task automatic t_held();
    logic [31:0] d;
    wr(CTRL0, 32'h1000);
    wr(CTRL1, 32'h0100_0000);
    repeat (3 * P) @(negedge clk);
    chk("R7 lines 12 and 56 held", rst_out, (64'h1 << 12) | (64'h1 << 56));
    rd(STAT0, d); chk("R3 stat0 shows held line", {32'h0, d}, {32'h0, ~32'h1000});
    rd(CTRL0, d); chk("R10 ctrl0 shows held line", {32'h0, d}, 64'h1000);
    wr(CTRL0, 32'h1008);
    chk("R7 rewrite with 1 keeps hold", rst_out, (64'h1 << 12) | (64'h1 << 56) | 64'h8);
    repeat (P) @(negedge clk);
    wr(CTRL0, 32'h0);
    chk("R7 zero releases line 12 only", rst_out, 64'h1 << 56);
    wr(CTRL1, 32'h0);
    chk("R7 zero releases line 56", rst_out, 64'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(STAT0, 32'hFFFF_FFFF);
    wr(12'h102, 32'hFFFF_FFFF);
    wr(12'h108, 32'hFFFF_FFFF);
    chk("R8 stray writes change no line", rst_out, 64'h0);
    rd(12'h108, d); chk("R8 unmapped read 0x108", {32'h0, d}, 64'h0);
    rd(12'h000, d); chk("R8 unmapped read 0x000", {32'h0, d}, 64'h0);
    rd(12'h101, d); chk("R8 unaligned read 0x101", {32'h0, d}, 64'h0);
  endtask

  task automatic t_sys();
    logic [31:0] d;
    wr(CTRL1, 32'h0100_0000);
    wr(CTRL0, 32'h1080);                 // line 12 held, line 7 pulse
    wr(CTRL0, 32'h0010_1001);            // system reset plus other bits
    chk("R9 only line 0 after system write", rst_out, 64'h1);
    wr(CTRL1, 32'h0100_0000);
    chk("R9 writes ignored during system pulse", rst_out, 64'h1);
    repeat (P - 2) @(negedge clk);
    chk("R9 system pulse full length", rst_out, 64'h1);
    @(negedge clk);
    chk("R9 all lines low after system pulse", rst_out, 64'h0);
    rd(STAT1, d); chk("R9 stat1 back to power-on", {32'h0, d}, 64'hFFFF_FFFF);
    rd(CTRL0, d); chk("R9 ctrl0 back to power-on", {32'h0, d}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_por();
    t_map();
    t_pulse();
    t_restart();
    t_zero();
    t_held();
    t_unmapped();
    t_sys();
    finish_run();
  end
endmodule